// File: doc/BRIEF.md
# Device Busy Wait Poller

This block guards a device that can only accept one long-running command at a time. When the command issuer launches an operation, the poller first sits out a minimum completion time given for that operation, during which it makes no read at all. It then reads a readiness word from the device through a simple request/acknowledge read port, one read at a time with a programmable pause between reads, until the device reports that it is ready. At that point it pulses `done_o` and goes idle, so the issuer may launch the next operation.

Two device variants are supported, chosen by `variant_i` when the operation is launched. Variant 0 reads a fixed status address and treats bit 30 of the returned word as the ready flag. Variant 1 reads the word at a base address plus 32 bytes and treats the device as ready only when that whole word is zero. If the device stays not-ready for the configured number of reads, the block pulses `timeout_o` and goes idle. A launch attempt while an operation is running is refused on `refused_o` and has no other effect.

Top module: `flash_ready_poller`

## Requirements
- R1: Out of reset the block is idle: `busy_o`, `rd_req_o`, `done_o`, `timeout_o` and `refused_o` are all 0.
- R2: A `start_i` seen while idle is accepted at that clock edge; `busy_o` is 1 from the next cycle until the cycle in which `done_o` or `timeout_o` pulses, when it is 0.
- R3: After acceptance, `rd_req_o` stays 0 for exactly max(`min_delay_i`,1) cycles and first rises in the following cycle (the `min_delay_i` value is taken at acceptance).
- R4: With `variant_i`=0 the read address is the status address (parameter `STATUS_ADDR`) and a response is ready when bit 30 of `rd_data_i` is 1, whatever the other bits hold.
- R5: With `variant_i`=1 the read address is `BASE_ADDR`+32 and a response is ready only when all 32 bits of `rd_data_i` are 0; any nonzero word, including one with only bit 30 set, is not ready.
- R6: At most one read is outstanding: once raised, `rd_req_o` stays 1 with a stable address until a cycle with `rd_ack_i`=1, which also delivers `rd_data_i`.
- R7: After a not-ready response that is not the last allowed, `rd_req_o` is 0 for exactly max(`poll_gap_i`,1) cycles and then rises again.
- R8: When the number of not-ready responses reaches max(`max_polls_i`,1), `timeout_o` is 1 for exactly one cycle, starting the cycle after that response, and the block is idle in that cycle.
- R9: A ready response makes `done_o` 1 for exactly one cycle, starting the cycle after the response, with the block idle in that cycle; `done_o` and `timeout_o` are never 1 together.
- R10: `start_i` while busy raises `refused_o` in the same cycle and does not restart, extend or reconfigure the running operation.
- R11: `variant_i`, `poll_gap_i` and `max_polls_i` are sampled at acceptance; changing them during an operation has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch request for a new operation |
| variant_i | input | 1 | Readiness encoding: 0 = status bit 30, 1 = zero word |
| min_delay_i | input | 16 | Minimum completion time in cycles |
| poll_gap_i | input | 16 | Idle cycles between successive reads |
| max_polls_i | input | 16 | Not-ready responses allowed before timeout |
| busy_o | output | 1 | Operation in progress |
| refused_o | output | 1 | Launch request refused because busy |
| done_o | output | 1 | One-cycle pulse: device reported ready |
| timeout_o | output | 1 | One-cycle pulse: poll limit reached |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | 32 | Read address |
| rd_ack_i | input | 1 | Read response valid |
| rd_data_i | input | 32 | Read response word |

## Verification
The hardest situation to reach is a launch attempt landing inside a running operation with different settings, combined with a response that is ready under one encoding and not under the other. The bench drives a second `start_i` with fresh random settings and flipped variant during the minimum-delay wait, then measures the delay and later gaps against the original values. Responses are drawn at random but steered per variant, including a word with only bit 30 set, so each read decides ready or not-ready on exactly the encoding under test, and operations run both to timeout and to success on the last allowed read.

// File: rtl/poll_pkg.sv
package poll_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_REQ  = 2'd2,
    ST_GAP  = 2'd3
  } poll_state_t;

endpackage

// File: rtl/poll_timer.sv
// Down-counter used for both the minimum delay and the poll spacing.
// A loaded value N makes the timer expire in its max(N,1)-th running cycle.
module poll_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign expire_o = run_i && (cnt_q <= CNT_W'(1));

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = load_val_i;
    end else if (run_i && (cnt_q > CNT_W'(1))) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/poll_counter.sv
// Counts not-ready responses and flags the one that reaches the limit.
module poll_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             last_o
);

  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic [EXT_W-1:0] lim_eff;
  logic [EXT_W-1:0] next_total;

  assign lim_eff    = (limit_i == '0) ? EXT_W'(1) : {1'b0, limit_i};
  assign next_total = {1'b0, cnt_q} + EXT_W'(1);
  assign last_o     = (next_total >= lim_eff);

  always_comb begin
    cnt_en = clear_i | inc_i;
    cnt_d  = clear_i ? '0 : (cnt_q + CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/ready_eval.sv
// Decides readiness of one response word under the selected encoding.
module ready_eval #(
  parameter int DATA_W    = 32,
  parameter int READY_BIT = 30
) (
  input  logic              variant_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o
);

  logic flag_ready;
  logic zero_ready;

  assign flag_ready = data_i[READY_BIT];
  assign zero_ready = (data_i == '0);
  assign ready_o    = variant_i ? zero_ready : flag_ready;

endmodule

// File: rtl/flash_ready_poller.sv
module flash_ready_poller
  import poll_pkg::*;
#(
  parameter int          CNT_W       = 16,
  parameter int          ADDR_W      = 32,
  parameter int          DATA_W      = 32,
  parameter int          READY_BIT   = 30,
  parameter logic [31:0] STATUS_ADDR = 32'h4000_0010,
  parameter logic [31:0] BASE_ADDR   = 32'h0002_0000,
  parameter int          BASE_OFFSET = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              variant_i,
  input  logic [CNT_W-1:0]  min_delay_i,
  input  logic [CNT_W-1:0]  poll_gap_i,
  input  logic [CNT_W-1:0]  max_polls_i,
  output logic              busy_o,
  output logic              refused_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i
);

  localparam logic [ADDR_W-1:0] ADDR_FLAG = ADDR_W'(STATUS_ADDR);
  localparam logic [ADDR_W-1:0] ADDR_ZERO = ADDR_W'(BASE_ADDR) + ADDR_W'(BASE_OFFSET);

  poll_state_t      st_q, st_d;
  logic             var_q;
  logic [CNT_W-1:0] gap_q;
  logic [CNT_W-1:0] lim_q;
  logic             done_q, done_d;
  logic             tmo_q, tmo_d;
  logic             accept;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_run;
  logic             tmr_exp;
  logic             cnt_clr;
  logic             cnt_inc;
  logic             cnt_last;
  logic             resp_ready;

  poll_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .run_i      (tmr_run),
    .expire_o   (tmr_exp)
  );

  poll_counter #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (cnt_clr),
    .inc_i   (cnt_inc),
    .limit_i (lim_q),
    .last_o  (cnt_last)
  );

  ready_eval #(.DATA_W(DATA_W), .READY_BIT(READY_BIT)) u_eval (
    .variant_i (var_q),
    .data_i    (rd_data_i),
    .ready_o   (resp_ready)
  );

  assign tmr_run = (st_q == ST_WAIT) || (st_q == ST_GAP);

  // next-state process
  always_comb begin
    st_d     = st_q;
    accept   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = min_delay_i;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    done_d   = 1'b0;
    tmo_d    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          accept   = 1'b1;
          tmr_load = 1'b1;
          cnt_clr  = 1'b1;
          st_d     = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (tmr_exp) st_d = ST_REQ;
      end
      ST_REQ: begin
        if (rd_ack_i) begin
          if (resp_ready) begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else if (cnt_last) begin
            tmo_d = 1'b1;
            st_d  = ST_IDLE;
          end else begin
            cnt_inc  = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = gap_q;
            st_d     = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        if (tmr_exp) st_d = ST_REQ;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      tmo_q  <= tmo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      var_q <= 1'b0;
      gap_q <= '0;
      lim_q <= '0;
    end else if (accept) begin
      var_q <= variant_i;
      gap_q <= poll_gap_i;
      lim_q <= max_polls_i;
    end
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign refused_o = start_i && busy_o;
  assign done_o    = done_q;
  assign timeout_o = tmo_q;
  assign rd_req_o  = (st_q == ST_REQ);
  assign rd_addr_o = var_q ? ADDR_ZERO : ADDR_FLAG;

endmodule

// File: rtl/flash_ready_poller_chk.sv
module flash_ready_poller_chk #(
  parameter int          CNT_W       = 16,
  parameter int          ADDR_W      = 32,
  parameter logic [31:0] STATUS_ADDR = 32'h4000_0010,
  parameter logic [31:0] BASE_ADDR   = 32'h0002_0000,
  parameter int          BASE_OFFSET = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [CNT_W-1:0]  min_delay_i,
  input logic              busy_o,
  input logic              refused_o,
  input logic              done_o,
  input logic              timeout_o,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_ack_i
);

  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(STATUS_ADDR);
  localparam logic [ADDR_W-1:0] A_ZERO = ADDR_W'(BASE_ADDR) + ADDR_W'(BASE_OFFSET);

  logic [CNT_W:0] wait_cnt;
  logic [CNT_W:0] wait_lim;
  logic           pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= '0;
      wait_lim <= '0;
      pend     <= 1'b0;
    end else if (start_i && !busy_o) begin
      wait_cnt <= '0;
      wait_lim <= (min_delay_i == '0) ? (CNT_W+1)'(1) : {1'b0, min_delay_i};
      pend     <= 1'b1;
    end else if (pend) begin
      if (rd_req_o) pend <= 1'b0;
      else          wait_cnt <= wait_cnt + (CNT_W+1)'(1);
    end
  end

  p_min_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && rd_req_o) |-> (wait_cnt == wait_lim));

  p_req_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> busy_o);

  p_addr_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> ((rd_addr_o == A_FLAG) || (rd_addr_o == A_ZERO)));  // R4 and R5

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

  p_tmo_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (!busy_o && !rd_req_o));

  p_tmo_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !timeout_o));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_refuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |-> refused_o);

  p_refuse_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    refused_o |-> busy_o);

endmodule

bind flash_ready_poller flash_ready_poller_chk #(
  .CNT_W       (CNT_W),
  .ADDR_W      (ADDR_W),
  .STATUS_ADDR (STATUS_ADDR),
  .BASE_ADDR   (BASE_ADDR),
  .BASE_OFFSET (BASE_OFFSET)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .min_delay_i (min_delay_i),
  .busy_o      (busy_o),
  .refused_o   (refused_o),
  .done_o      (done_o),
  .timeout_o   (timeout_o),
  .rd_req_o    (rd_req_o),
  .rd_addr_o   (rd_addr_o),
  .rd_ack_i    (rd_ack_i)
);

// File: tb/flash_ready_poller_tb.sv
`timescale 1ns/1ps
module flash_ready_poller_tb;

  localparam logic [31:0] STATUS_ADDR = 32'h4000_0010;
  localparam logic [31:0] BASE_ADDR   = 32'h0002_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        variant_i = 1'b0;
  logic [15:0] min_delay_i = '0;
  logic [15:0] poll_gap_i = '0;
  logic [15:0] max_polls_i = '0;
  logic        busy_o, refused_o, done_o, timeout_o, rd_req_o;
  logic [31:0] rd_addr_o;
  logic        rd_ack_i = 1'b0;
  logic [31:0] rd_data_i = '0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_ready_poller u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .variant_i(variant_i),
    .min_delay_i(min_delay_i), .poll_gap_i(poll_gap_i), .max_polls_i(max_polls_i),
    .busy_o(busy_o), .refused_o(refused_o), .done_o(done_o), .timeout_o(timeout_o),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i)
  );

  function automatic int eff(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic logic [31:0] exp_addr(input bit v);
    return v ? (BASE_ADDR + 32'd32) : STATUS_ADDR;
  endfunction

  function automatic logic [31:0] make_word(input bit v, input bit ready);
    logic [31:0] w;
    w = $urandom;
    if (!v) w[30] = ready;
    else if (ready) w = '0;
    else if (w == '0) w = 32'h0000_0100;
    return w;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Runs one operation. k = number of not-ready responses before a ready one.
  // special: 1 = respond to variant 0 with only bit 30 set as a not-ready word in variant 1
  task automatic run_op(input bit v, input int d, input int g, input int m,
                        input int k, input bit poke, input bit special);
    int cnt;
    int polls;
    int expw;
    int lat;
    int mlim;
    bit rdy;
    logic [31:0] a0;
    mlim = eff(m);
    start_i = 1'b1; variant_i = v;
    min_delay_i = 16'(d); poll_gap_i = 16'(g); max_polls_i = 16'(m);
    @(negedge clk);
    start_i = 1'b0;
    // R11: change the sampled settings mid-operation
    variant_i = ~v; poll_gap_i = 16'($urandom_range(0, 12));
    max_polls_i = 16'($urandom_range(0, 8)); min_delay_i = 16'($urandom_range(0, 40));
    check("R2 busy after accept", 64'(busy_o), 64'd1);
    cnt = 1;
    if (poke) begin
      start_i = 1'b1;
      #1 check("R10 refused while busy", 64'(refused_o), 64'd1);
      @(negedge clk); cnt++;
      start_i = 1'b0;
    end
    expw = eff(d) + 1;
    polls = 0;
    forever begin
      while (!rd_req_o && cnt < 70000) begin @(negedge clk); cnt++; end
      if (polls == 0) check("R3 min delay before first read", 64'(cnt), 64'(expw));
      else            check("R7 poll spacing", 64'(cnt), 64'(expw));
      check(v ? "R5 zero-word address" : "R4 status address", 64'(rd_addr_o), 64'(exp_addr(v)));
      a0 = rd_addr_o;
      lat = $urandom_range(0, 3);
      repeat (lat) begin
        @(negedge clk);
        check("R6 request held", 64'({rd_req_o, rd_addr_o}), 64'({1'b1, a0}));
      end
      rdy = (polls >= k);
      rd_ack_i = 1'b1;
      if (special) rd_data_i = rdy ? (v ? 32'h0 : 32'h4000_0000) : (v ? 32'h4000_0000 : 32'hBFFF_FFFF);
      else         rd_data_i = make_word(v, rdy);
      @(negedge clk);
      rd_ack_i = 1'b0; rd_data_i = $urandom;
      cnt = 1;
      polls++;
      if (rdy) begin
        check("R9 done pulse", 64'({done_o, timeout_o, busy_o}), 64'({1'b1, 1'b0, 1'b0}));
        @(negedge clk);
        check("R9 done one cycle", 64'(done_o), 64'd0);
        break;
      end else if (polls == mlim) begin
        check("R8 timeout pulse", 64'({timeout_o, done_o, busy_o}), 64'({1'b1, 1'b0, 1'b0}));
        @(negedge clk);
        check("R8 timeout one cycle", 64'(timeout_o), 64'd0);
        break;
      end else begin
        check("R7 no pulse mid-poll", 64'({done_o, timeout_o, busy_o}), 64'({1'b0, 1'b0, 1'b1}));
        expw = eff(g) + 1;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 reset idle", 64'({busy_o, rd_req_o, done_o, timeout_o, refused_o}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", 64'({busy_o, rd_req_o, done_o, timeout_o}), 64'd0);
    // directed corners
    run_op(1'b0, 0, 0, 0, 0, 1'b0, 1'b0);   // zero delay, immediate ready
    run_op(1'b0, 1, 1, 1, 5, 1'b0, 1'b0);   // single poll allowed -> timeout
    run_op(1'b1, 5, 0, 0, 3, 1'b1, 1'b0);   // limit 0 acts as 1 -> timeout
    run_op(1'b0, 7, 3, 4, 3, 1'b1, 1'b1);   // ready on last allowed poll, bit-only words
    run_op(1'b1, 4, 2, 3, 9, 1'b0, 1'b1);   // bit 30 alone is not ready in zero-word mode
    run_op(1'b1, 2, 5, 6, 2, 1'b1, 1'b0);
    // random operations
    for (int i = 0; i < 40; i++) begin
      int m;
      m = $urandom_range(0, 6);
      run_op(1'($urandom_range(0, 1)), $urandom_range(0, 30), $urandom_range(0, 10),
             m, $urandom_range(0, 7), 1'($urandom_range(0, 1)), 1'b0);
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
    check("R2 idle at end", 64'(busy_o), 64'd0);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule